// File: doc/BRIEF.md
# Hit Packet Handshake Merge Stage

This block is one link of a readout chain for hit data. It forms a 20-bit hit packet from a local hit and merges it with packets arriving from the stage before it. The merged stream leaves on a downstream port. Both the local and upstream inputs use a four-phase return-to-zero request/acknowledge handshake, and so does the downstream output. No global control or high-rate strobe is involved in a transfer: each move is started by a request and finished by the matching acknowledge. The register stage samples the handshake lines on a local clock, which stands in for the asynchronous cells.

Local packets are built from two parts. The stage's own chip identifier (or timestamp) and its super-column address are static inputs. The pixel address and the amplitude arrive with the local request. Upstream packets pass through the stage unchanged. When both sources wait at the same time, the stage serves them in turn. A mode input replaces the parallel downstream handshake with a bit-serial frame on a single wire.

Top module: `hit_link_stage`

## Requirements
- R1: A local packet appears downstream as {chip_id[2:0], scol_addr[5:0], loc_pix[7:0], loc_amp[2:0]}, with chip_id in bits 19:17 and loc_amp in bits 2:0. An upstream packet appears downstream bit for bit as it was presented on up_data.
- R2: A source acknowledge rises only on a clock edge at which that source's request is high. It stays high while the request stays high. It falls on the first edge at which the request is low.
- R3: In parallel mode, dn_req stays high and dn_data stays stable until dn_ack is seen high. dn_req then falls, and no new request is raised until dn_ack has returned low.
- R4: When local and upstream requests are pending together, the stage grants the source it did not grant last. After reset, a tie goes to the local source first.
- R5: A source that is the only one pending is served on every free slot, so its packets leave in the order given.
- R6: With serial_mode high, each packet leaves on ser_out as a 1 start bit followed by the 20 packet bits MSB first, one per clock, 21 clocks in all. dn_req stays low, and ser_out is 0 between frames.
- R7: Asserting rst_n low drives dn_req, loc_ack, up_ack and ser_out to 0 and discards a packet in flight. That packet is never delivered after reset.
- R8: No clock edge raises both loc_ack and up_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the handshake stage |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| chip_id | input | 3 | Static chip identifier or timestamp field |
| scol_addr | input | 6 | Static super-column address |
| serial_mode | input | 1 | 1: bit-serial output, 0: parallel handshake output |
| loc_req | input | 1 | Local hit request |
| loc_pix | input | 8 | Local pixel address |
| loc_amp | input | 3 | Local hit amplitude |
| loc_ack | output | 1 | Local hit acknowledge |
| up_req | input | 1 | Upstream packet request |
| up_data | input | 20 | Upstream packet |
| up_ack | output | 1 | Upstream acknowledge |
| dn_req | output | 1 | Downstream request |
| dn_data | output | 20 | Downstream packet |
| dn_ack | input | 1 | Downstream acknowledge |
| ser_out | output | 1 | Serial frame output |

## Verification
Two things can fall on one clock edge: a local request and an upstream request arriving together. The bench provokes this by raising both requests at the same instant and keeping both sources loaded, so that every free slot meets a tie. The order of the packets received must then alternate and start with the local one. A second overlap is the release of one source's acknowledge on the same edge that captures the other source. This is judged by the bench's per-clock check that acknowledges never rise together and that every packet arrives exactly once.

// File: rtl/hit_pkt_pkg.sv
package hit_pkt_pkg;
  localparam int CHIP_W = 3;
  localparam int SCOL_W = 6;
  localparam int PIX_W  = 8;
  localparam int AMP_W  = 3;
  localparam int PKT_W  = CHIP_W + SCOL_W + PIX_W + AMP_W;
  localparam int CNT_W  = $clog2(PKT_W + 1);

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_REQ   = 2'd1,
    TX_REL   = 2'd2,
    TX_SHIFT = 2'd3
  } tx_state_t;

  function automatic logic [PKT_W-1:0] pack_hit(
    input logic [CHIP_W-1:0] chip,
    input logic [SCOL_W-1:0] scol,
    input logic [PIX_W-1:0]  pix,
    input logic [AMP_W-1:0]  amp);
    return {chip, scol, pix, amp};
  endfunction
endpackage

// File: rtl/hs_port.sv
module hs_port (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic grant,
  output logic ack,
  output logic pending
);
  logic ack_nxt;

  assign pending = req & ~ack;

  always_comb begin
    if (ack) ack_nxt = req;
    else     ack_nxt = grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_nxt;
  end

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req));
  a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !ack);
endmodule

// File: rtl/rr_pick.sv
module rr_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic pend_loc,
  input  logic pend_up,
  output logic gnt_loc,
  output logic gnt_up
);
  logic last_up, last_up_nxt;

  always_comb begin
    gnt_loc     = take & pend_loc & (~pend_up | last_up);
    gnt_up      = take & pend_up & ~gnt_loc;
    last_up_nxt = last_up;
    if (gnt_loc)     last_up_nxt = 1'b0;
    else if (gnt_up) last_up_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_up <= 1'b1;
    else        last_up <= last_up_nxt;
  end

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_loc, gnt_up}));
endmodule

// File: rtl/link_tx.sv
module link_tx
  import hit_pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serial_mode,
  input  logic             load,
  input  logic [PKT_W-1:0] pkt_in,
  input  logic             dn_ack,
  output logic             idle,
  output logic             dn_req,
  output logic [PKT_W-1:0] dn_data,
  output logic             ser_out
);
  tx_state_t        state, state_nxt;
  logic [PKT_W-1:0] pkt_q, pkt_nxt;
  logic [PKT_W:0]   sh_q, sh_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    state_nxt = state;
    pkt_nxt   = pkt_q;
    sh_nxt    = sh_q;
    cnt_nxt   = cnt_q;
    unique case (state)
      TX_IDLE: if (load) begin
        pkt_nxt = pkt_in;
        if (serial_mode) begin
          sh_nxt    = {1'b1, pkt_in};
          cnt_nxt   = '0;
          state_nxt = TX_SHIFT;
        end else begin
          state_nxt = TX_REQ;
        end
      end
      TX_REQ:  if (dn_ack)  state_nxt = TX_REL;
      TX_REL:  if (!dn_ack) state_nxt = TX_IDLE;
      TX_SHIFT: begin
        sh_nxt  = {sh_q[PKT_W-1:0], 1'b0};
        cnt_nxt = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(PKT_W)) state_nxt = TX_IDLE;
      end
      default: state_nxt = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      pkt_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      state <= state_nxt;
      pkt_q <= pkt_nxt;
      sh_q  <= sh_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign idle    = (state == TX_IDLE);
  assign dn_req  = (state == TX_REQ);
  assign dn_data = pkt_q;
  assign ser_out = (state == TX_SHIFT) & sh_q[PKT_W];

  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> dn_req);
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && $past(dn_req)) |-> $stable(dn_data));
  a_r3_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_req && dn_ack) |=> !dn_req);
  a_r6_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_SHIFT) |-> (cnt_q <= CNT_W'(PKT_W)));
endmodule

// File: rtl/hit_link_stage.sv
module hit_link_stage
  import hit_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic [SCOL_W-1:0] scol_addr,
  input  logic              serial_mode,
  input  logic              loc_req,
  input  logic [PIX_W-1:0]  loc_pix,
  input  logic [AMP_W-1:0]  loc_amp,
  output logic              loc_ack,
  input  logic              up_req,
  input  logic [PKT_W-1:0]  up_data,
  output logic              up_ack,
  output logic              dn_req,
  output logic [PKT_W-1:0]  dn_data,
  input  logic              dn_ack,
  output logic              ser_out
);
  logic pend_loc, pend_up, gnt_loc, gnt_up, tx_idle;
  logic [PKT_W-1:0] pkt_sel;

  hs_port u_loc (.clk(clk), .rst_n(rst_n), .req(loc_req), .grant(gnt_loc),
                 .ack(loc_ack), .pending(pend_loc));
  hs_port u_up  (.clk(clk), .rst_n(rst_n), .req(up_req), .grant(gnt_up),
                 .ack(up_ack), .pending(pend_up));

  rr_pick u_arb (.clk(clk), .rst_n(rst_n), .take(tx_idle),
                 .pend_loc(pend_loc), .pend_up(pend_up),
                 .gnt_loc(gnt_loc), .gnt_up(gnt_up));

  assign pkt_sel = gnt_loc ? pack_hit(chip_id, scol_addr, loc_pix, loc_amp) : up_data;

  link_tx u_tx (.clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
                .load(gnt_loc | gnt_up), .pkt_in(pkt_sel), .dn_ack(dn_ack),
                .idle(tx_idle), .dn_req(dn_req), .dn_data(dn_data),
                .ser_out(ser_out));

  a_r8_no_dual_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(loc_ack) && $rose(up_ack)));
  a_r6_serial_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out) |-> !dn_req);
endmodule

// File: tb/tb_hit_link_stage.sv
module tb_hit_link_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] chip_id = 3'b101;
  logic [5:0] scol_addr = 6'b100111;
  logic serial_mode = 1'b0;
  logic loc_req = 1'b0;
  logic [7:0] loc_pix = '0;
  logic [2:0] loc_amp = '0;
  logic loc_ack;
  logic up_req = 1'b0;
  logic [19:0] up_data = '0;
  logic up_ack;
  logic dn_req;
  logic [19:0] dn_data;
  logic dn_ack = 1'b0;
  logic ser_out;

  int checks = 0;
  int errors = 0;
  bit cons_en = 1'b0;
  bit done = 1'b0;
  logic [19:0] exp_q[$];

  always #2.5 clk = ~clk;

  hit_link_stage dut (.clk(clk), .rst_n(rst_n), .chip_id(chip_id), .scol_addr(scol_addr),
    .serial_mode(serial_mode), .loc_req(loc_req), .loc_pix(loc_pix), .loc_amp(loc_amp),
    .loc_ack(loc_ack), .up_req(up_req), .up_data(up_data), .up_ack(up_ack),
    .dn_req(dn_req), .dn_data(dn_data), .dn_ack(dn_ack), .ser_out(ser_out));

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] loc_pkt(input logic [7:0] p, input logic [2:0] a);
    return {chip_id, scol_addr, p, a};   // R1 field layout
  endfunction

  task automatic send_loc(input logic [7:0] p, input logic [2:0] a);
    @(negedge clk);
    loc_pix = p; loc_amp = a; loc_req = 1'b1;
    while (!loc_ack) @(negedge clk);
    loc_req = 1'b0;
    while (loc_ack) @(negedge clk);
  endtask

  task automatic send_up(input logic [19:0] d);
    @(negedge clk);
    up_data = d; up_req = 1'b1;
    while (!up_ack) @(negedge clk);
    up_req = 1'b0;
    while (up_ack) @(negedge clk);
  endtask

  // downstream consumer and R1/R3 packet check
  initial forever begin
    @(negedge clk);
    if (cons_en && dn_req && !dn_ack) begin
      logic [19:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 20'hxxxxx;
      chk(dn_data === e, "R1/R4/R5 packet order", dn_data, e);
      repeat (3) @(negedge clk);
      dn_ack = 1'b1;
      while (dn_req) @(negedge clk);
      repeat (2) @(negedge clk);
      dn_ack = 1'b0;
    end
  end

  // per-clock handshake checks R2, R3, R8
  logic p_req, p_ack, p_lack, p_lreq, p_uack, p_ureq;
  logic [19:0] p_data;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (p_req && !p_ack) begin
        chk(dn_req === 1'b1, "R3 req held", 20'(dn_req), 20'd1);
        chk(dn_data === p_data, "R3 data stable", dn_data, p_data);
      end
      if (!p_req && p_ack) chk(dn_req === 1'b0, "R3 no req before ack low", 20'(dn_req), 20'd0);
      if (loc_ack && !p_lack) chk(p_lreq === 1'b1, "R2 loc ack needs req", 20'(p_lreq), 20'd1);
      if (up_ack && !p_uack)  chk(p_ureq === 1'b1, "R2 up ack needs req", 20'(p_ureq), 20'd1);
      if (p_lack && !p_lreq)  chk(loc_ack === 1'b0, "R2 loc ack release", 20'(loc_ack), 20'd0);
      chk(!(loc_ack && !p_lack && up_ack && !p_uack), "R8 single ack", 20'({loc_ack, up_ack}), 20'd0);
    end
    p_req = dn_req; p_ack = dn_ack; p_data = dn_data;
    p_lack = loc_ack; p_lreq = loc_req; p_uack = up_ack; p_ureq = up_req;
  end

  task automatic rx_serial(input logic [19:0] e);
    logic [19:0] got;
    @(negedge clk);
    while (!ser_out) @(negedge clk);
    chk(dn_req === 1'b0, "R6 dn_req low in serial", 20'(dn_req), 20'd0);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      got[i] = ser_out;
      chk(dn_req === 1'b0, "R6 dn_req low in serial", 20'(dn_req), 20'd0);
    end
    chk(got === e, "R6 serial frame", got, e);
    @(negedge clk);
    chk(ser_out === 1'b0, "R6 idle after 21 bits", 20'(ser_out), 20'd0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk({dn_req, loc_ack, up_ack, ser_out} === 4'b0, "R7 reset outputs", 20'({dn_req, loc_ack, up_ack, ser_out}), 20'd0);
    rst_n = 1'b1;
    cons_en = 1'b1;

    // R4 tie, local first, then alternate
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(loc_pkt(8'h10 + 8'(i), 3'(i + 1)));
      exp_q.push_back(20'hA5A50 + 20'(i));
    end
    fork
      for (int i = 0; i < 3; i++) send_loc(8'h10 + 8'(i), 3'(i + 1));
      for (int i = 0; i < 3; i++) send_up(20'hA5A50 + 20'(i));
    join
    while (exp_q.size() > 0 || dn_req || dn_ack) @(negedge clk);

    // R5 single source: upstream only, then local only
    exp_q.push_back(20'hFFFFF); exp_q.push_back(20'h00001);
    send_up(20'hFFFFF); send_up(20'h00001);
    exp_q.push_back(loc_pkt(8'hFF, 3'd7)); exp_q.push_back(loc_pkt(8'h00, 3'd0));
    send_loc(8'hFF, 3'd7); send_loc(8'h00, 3'd0);
    while (exp_q.size() > 0 || dn_req || dn_ack) @(negedge clk);
    chk(20'(exp_q.size()) === 20'd0, "R5 all delivered", 20'(exp_q.size()), 20'd0);

    // R6 serial mode
    serial_mode = 1'b1;
    fork send_loc(8'h3C, 3'd5); rx_serial(loc_pkt(8'h3C, 3'd5)); join
    fork send_up(20'h80001); rx_serial(20'h80001); join
    repeat (3) @(negedge clk);
    serial_mode = 1'b0;

    // R7 reset mid-packet discards it
    cons_en = 1'b0;
    @(negedge clk);
    loc_pix = 8'h77; loc_amp = 3'd3; loc_req = 1'b1;
    while (!dn_req) @(negedge clk);
    rst_n = 1'b0; loc_req = 1'b0;
    #1;
    chk({dn_req, loc_ack, up_ack, ser_out} === 4'b0, "R7 reset clears lines", 20'({dn_req, loc_ack, up_ack, ser_out}), 20'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dn_req === 1'b0, "R7 discarded packet not resent", 20'(dn_req), 20'd0);
    cons_en = 1'b1;
    exp_q.push_back(loc_pkt(8'h42, 3'd6));
    send_loc(8'h42, 3'd6);
    while (exp_q.size() > 0 || dn_req || dn_ack) @(negedge clk);
    chk(20'(exp_q.size()) === 20'd0, "R7 next packet delivered", 20'(exp_q.size()), 20'd0);
    finish_run();
  end
endmodule